// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Resolver

The resolver turns an interrupt command into the set of processors that must receive it. A command is two 32-bit words. The lower word is presented together with a write strobe. The upper word carries the 8-bit destination and must be stable while the strobe is high. The block also receives a table that describes every local unit: its 8-bit ID, its 8-bit logical destination and its 4-bit destination model. The sender's index selects the unit that issued the command.

The resolver picks candidates in one of three ways: by physical ID, by logical flat or cluster matching, or by a destination shorthand that overrides the destination field. It then applies the delivery-mode rules. Lowest-priority delivery is reduced to the lowest-indexed candidate. An INIT de-assert delivers nothing and instead flags the units that must copy their ID into their arbitration ID. One cycle after the strobe, the result appears as a registered target bitmask with a valid pulse, together with the delivery mode and vector taken from the command.

Top module: `ipi_dest_resolver`

## Requirements
- R1: In physical mode (lower word bit 11 = 0) with shorthand 0, a destination of 0xFF selects every unit.
- R2: In physical mode with shorthand 0, any destination other than 0xFF selects only the lowest-indexed unit whose ID equals the destination. If no ID matches, no unit is selected.
- R3: In logical mode (bit 11 = 1), a unit whose model is 0xF matches when the destination AND its logical destination is nonzero.
- R4: In logical mode, a unit whose model is 0x0 matches when the upper nibbles of the destination and of its logical destination are equal and the AND of their lower nibbles is nonzero. A unit with any other model code never matches.
- R5: The shorthand in lower word bits 19:18 overrides the destination field: 1 selects only the sender, 2 selects all units, 3 selects all units except the sender.
- R6: Field positions are as follows. The delivery mode is in lower bits 10:8, the level in bit 14, the trigger in bit 15 and the vector in bits 7:0. The destination is in upper bits 31:24. The result echoes the mode and the vector.
- R7: For delivery mode 1 (lowest priority), the target mask keeps only the lowest-indexed unit of the candidate set.
- R8: For delivery mode 5 (INIT) with level 0 and trigger 1, the target mask is zero and the arbitration-load mask equals the candidate set. For any other command, the arbitration-load mask is zero.
- R9: The following modes deliver to the full candidate set: 0 fixed, 2 SMI, 4 NMI, 5 INIT other than de-assert, 6 startup and 7 external. The reserved code 3 delivers to no unit.
- R10: The valid output is high in exactly the cycle after a strobe cycle and low otherwise. Without a strobe, all result outputs hold their last values.
- R11: After reset, valid, target mask, arbitration-load mask, mode and vector are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_lo_we | input | 1 | Write strobe of the lower command word |
| cmd_lo | input | 32 | Lower command word (vector, mode, destination mode, level, trigger, shorthand) |
| cmd_hi | input | 32 | Upper command word, destination in bits 31:24 |
| sender_idx | input | IDX_W | Index of the issuing unit |
| unit_id | input | N_UNITS*8 | Packed IDs, unit i at bits 8i+7:8i |
| unit_ldest | input | N_UNITS*8 | Packed logical destinations |
| unit_model | input | N_UNITS*4 | Packed destination models, unit i at bits 4i+3:4i |
| out_valid | output | 1 | Result valid pulse |
| out_mask | output | N_UNITS | Units that receive the interrupt |
| out_arb_load | output | N_UNITS | Units that load their arbitration ID (INIT de-assert) |
| out_mode | output | 3 | Delivery mode of the result |
| out_vector | output | 8 | Vector of the result |

## Verification
The shorthand override and the delivery-mode reduction act on the same command in the same cycle. The most telling combination is shorthand 3 with lowest priority: the single target must be the lowest-indexed unit other than the sender, so the sender sitting at index 0 moves the answer. The sweep drives every destination value in both addressing modes under all four shorthands, while the mode and the sender index are rotated with the destination. Each result is compared with a mask computed in the bench by looping over the unit table. Two unit tables are used: one with a duplicated ID, mixed flat and cluster models and an unsupported model code, and one that is mostly flat.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXTINT = 3'd7
    } dmode_e;

    typedef enum logic [1:0] {
        SH_FIELD    = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL      = 2'd2,
        SH_ALL_OTHR = 2'd3
    } short_e;

    localparam int VEC_LSB   = 0;
    localparam int MODE_LSB  = 8;
    localparam int LOGIC_BIT = 11;
    localparam int LEVEL_BIT = 14;
    localparam int TRIG_BIT  = 15;
    localparam int SH_LSB    = 18;
    localparam int DEST_LSB  = 24;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
    localparam logic [7:0] DEST_BCAST    = 8'hFF;

endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match
    import ipi_pkg::*;
(
    input  logic [7:0] dest,
    input  logic [7:0] uid,
    input  logic [7:0] ldest,
    input  logic [3:0] model,
    output logic       phys_hit,
    output logic       log_hit
);
    logic flat_hit;
    logic clus_hit;

    always_comb begin
        phys_hit = (uid == dest);
        flat_hit = (model == MODEL_FLAT) && ((dest & ldest) != 8'h00);
        clus_hit = (model == MODEL_CLUSTER)
                 && (dest[7:4] == ldest[7:4])
                 && ((dest[3:0] & ldest[3:0]) != 4'h0);
        log_hit  = flat_hit | clus_hit;
    end
endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] pick
);
    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pick[i]   = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
    import ipi_pkg::*;
#(
    parameter int N_UNITS = 8,
    localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_lo_we,
    input  logic [31:0]            cmd_lo,
    input  logic [31:0]            cmd_hi,
    input  logic [IDX_W-1:0]       sender_idx,
    input  logic [N_UNITS*8-1:0]   unit_id,
    input  logic [N_UNITS*8-1:0]   unit_ldest,
    input  logic [N_UNITS*4-1:0]   unit_model,
    output logic                   out_valid,
    output logic [N_UNITS-1:0]     out_mask,
    output logic [N_UNITS-1:0]     out_arb_load,
    output logic [2:0]             out_mode,
    output logic [7:0]             out_vector
);

    typedef struct packed {
        logic               valid;
        logic [N_UNITS-1:0] mask;
        logic [N_UNITS-1:0] arb;
        logic [2:0]         mode;
        logic [7:0]         vector;
    } res_t;

    res_t res_d, res_q;

    // command fields
    logic [7:0]         dest;
    logic               logical;
    logic [1:0]         shorthand;
    logic [2:0]         mode;
    logic [7:0]         vector;
    logic               lvl;
    logic               trig;

    // per-unit match results
    logic [N_UNITS-1:0] phys_hits;
    logic [N_UNITS-1:0] log_hits;
    logic [N_UNITS-1:0] phys_first;
    logic [N_UNITS-1:0] cand;
    logic [N_UNITS-1:0] cand_first;
    logic [N_UNITS-1:0] self_bit;
    logic [N_UNITS-1:0] field_mask;

    always_comb begin
        dest      = cmd_hi[DEST_LSB +: 8];
        logical   = cmd_lo[LOGIC_BIT];
        shorthand = cmd_lo[SH_LSB +: 2];
        mode      = cmd_lo[MODE_LSB +: 3];
        vector    = cmd_lo[VEC_LSB +: 8];
        lvl       = cmd_lo[LEVEL_BIT];
        trig      = cmd_lo[TRIG_BIT];
    end

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        ipi_unit_match u_match (
            .dest     (dest),
            .uid      (unit_id[u*8 +: 8]),
            .ldest    (unit_ldest[u*8 +: 8]),
            .model    (unit_model[u*4 +: 4]),
            .phys_hit (phys_hits[u]),
            .log_hit  (log_hits[u])
        );
    end

    // duplicate IDs: the lowest index wins
    ipi_lowest_pick #(.WIDTH(N_UNITS)) u_phys_pick (
        .req  (phys_hits),
        .pick (phys_first)
    );

    always_comb begin
        self_bit = '0;
        self_bit[sender_idx] = 1'b1;

        if (logical) begin
            field_mask = log_hits;
        end else if (dest == DEST_BCAST) begin
            field_mask = '1;
        end else begin
            field_mask = phys_first;
        end

        unique case (short_e'(shorthand))
            SH_FIELD:    cand = field_mask;
            SH_SELF:     cand = self_bit;
            SH_ALL:      cand = '1;
            SH_ALL_OTHR: cand = ~self_bit;
            default:     cand = '0;
        endcase
    end

    ipi_lowest_pick #(.WIDTH(N_UNITS)) u_cand_pick (
        .req  (cand),
        .pick (cand_first)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (cmd_lo_we) begin
            res_d.valid  = 1'b1;
            res_d.mode   = mode;
            res_d.vector = vector;
            res_d.arb    = '0;
            unique case (dmode_e'(mode))
                DM_LOWPRI: res_d.mask = cand_first;
                DM_RSVD:   res_d.mask = '0;
                DM_INIT: begin
                    if (!lvl && trig) begin
                        res_d.mask = '0;
                        res_d.arb  = cand;
                    end else begin
                        res_d.mask = cand;
                    end
                end
                default:   res_d.mask = cand;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.valid;
    assign out_mask     = res_q.mask;
    assign out_arb_load = res_q.arb;
    assign out_mode     = res_q.mode;
    assign out_vector   = res_q.vector;

endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
    parameter int N_UNITS = 8,
    localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_lo_we,
    input logic [31:0]        cmd_lo,
    input logic [IDX_W-1:0]   sender_idx,
    input logic               out_valid,
    input logic [N_UNITS-1:0] out_mask,
    input logic [N_UNITS-1:0] out_arb_load,
    input logic [2:0]         out_mode,
    input logic [7:0]         out_vector
);

    assert_valid_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lo_we |=> out_valid);

    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_lo_we |=> !out_valid);

    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_lo_we |=> ($stable(out_mask) && $stable(out_arb_load) && $stable(out_mode)));

    assert_echo_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lo_we |=> (out_mode == $past(cmd_lo[10:8]) && out_vector == $past(cmd_lo[7:0])));

    assert_lowpri_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 3'd1) |-> $onehot0(out_mask));

    assert_init_deassert_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lo_we && cmd_lo[10:8] == 3'd5 && cmd_lo[15:14] == 2'b10) |=> (out_mask == '0));

    assert_arb_only_on_deassert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lo_we && !(cmd_lo[10:8] == 3'd5 && cmd_lo[15:14] == 2'b10)) |=> (out_arb_load == '0));

    assert_reserved_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 3'd3) |-> (out_mask == '0));

    assert_self_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lo_we && cmd_lo[19:18] == 2'd1) |=> ($countones(out_mask | out_arb_load) <= 1));

    assert_all_but_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lo_we && cmd_lo[19:18] == 2'd3) |=> !(out_mask[$past(sender_idx)] || out_arb_load[$past(sender_idx)]));

endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.N_UNITS(N_UNITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_lo_we    (cmd_lo_we),
    .cmd_lo       (cmd_lo),
    .sender_idx   (sender_idx),
    .out_valid    (out_valid),
    .out_mask     (out_mask),
    .out_arb_load (out_arb_load),
    .out_mode     (out_mode),
    .out_vector   (out_vector)
);

// File: tb/tb_ipi_dest_resolver.sv
`timescale 1ns/1ps
module tb_ipi_dest_resolver;
    localparam int N     = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_lo_we = 1'b0;
    logic [31:0]      cmd_lo = '0;
    logic [31:0]      cmd_hi = '0;
    logic [IDX_W-1:0] sender_idx = '0;
    logic [N*8-1:0]   unit_id;
    logic [N*8-1:0]   unit_ldest;
    logic [N*4-1:0]   unit_model;
    logic             out_valid;
    logic [N-1:0]     out_mask;
    logic [N-1:0]     out_arb_load;
    logic [2:0]       out_mode;
    logic [7:0]       out_vector;

    logic [7:0] uid [N];
    logic [7:0] uld [N];
    logic [3:0] umd [N];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            unit_id[i*8 +: 8]    = uid[i];
            unit_ldest[i*8 +: 8] = uld[i];
            unit_model[i*4 +: 4] = umd[i];
        end
    end

    ipi_dest_resolver #(.N_UNITS(N)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_lo_we(cmd_lo_we), .cmd_lo(cmd_lo),
        .cmd_hi(cmd_hi), .sender_idx(sender_idx), .unit_id(unit_id),
        .unit_ldest(unit_ldest), .unit_model(unit_model), .out_valid(out_valid),
        .out_mask(out_mask), .out_arb_load(out_arb_load), .out_mode(out_mode),
        .out_vector(out_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input int cfg);
        for (int i = 0; i < N; i++) begin
            if (cfg == 0) begin
                uid[i] = 8'h20 + 8'(i * 3);
                umd[i] = (i == 7) ? 4'h9 : ((i % 2 == 1) ? 4'h0 : 4'hF);
                if (i % 2 == 1) uld[i] = {((i % 4 == 1) ? 4'h3 : 4'h5), 4'(1 << (i % 4))};
                else            uld[i] = 8'(1 << i);
            end else begin
                uid[i] = 8'hFF - 8'(i * 17);
                uld[i] = 8'(i * 37 + 5);
                umd[i] = (i == 3) ? 4'h0 : 4'hF;
            end
        end
        if (cfg == 0) uid[6] = uid[2];
    endtask

    function automatic logic [N-1:0] cand_set(input logic [7:0] d, input bit lg,
                                              input int sh, input int snd);
        logic [N-1:0] m = '0;
        if (sh == 1) begin
            m[snd] = 1'b1;
        end else if (sh == 2) begin
            m = '1;
        end else if (sh == 3) begin
            m = '1; m[snd] = 1'b0;
        end else if (!lg) begin
            if (d == 8'hFF) m = '1;
            else begin
                for (int i = N - 1; i >= 0; i--)
                    if (uid[i] == d) m = N'(1) << i;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (umd[i] == 4'hF) m[i] = (d & uld[i]) != 0;
                else if (umd[i] == 4'h0)
                    m[i] = (d[7:4] == uld[i][7:4]) && ((d[3:0] & uld[i][3:0]) != 0);
            end
        end
        return m;
    endfunction

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        load_cfg(0);
        repeat (3) @(negedge clk);
        check("R11 valid", 32'(out_valid), 0);
        check("R11 mask", 32'(out_mask), 0);
        check("R11 arb", 32'(out_arb_load), 0);
        check("R11 mode/vector", {21'd0, out_mode, out_vector}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle valid", 32'(out_valid), 0);

        n = 0;
        for (int cfg = 0; cfg < 2; cfg++) begin
            load_cfg(cfg);
            for (int d = 0; d < 256; d++) begin
                for (int lg = 0; lg < 2; lg++) begin
                    for (int sh = 0; sh < 4; sh++) begin
                        logic [N-1:0] c, em, ea, low;
                        int md, snd;
                        logic lv, tr;
                        string tag;
                        md  = (d + sh + cfg + lg) % 8;
                        snd = (d / 2 + sh) % N;
                        lv  = d[0];
                        tr  = d[1];
                        c   = cand_set(8'(d), lg[0], sh, snd);
                        low = '0;
                        for (int i = N - 1; i >= 0; i--) if (c[i]) low = N'(1) << i;
                        em = c; ea = '0;
                        if (md == 1) em = low;
                        else if (md == 3) em = '0;
                        else if (md == 5 && !lv && tr) begin em = '0; ea = c; end
                        if (md == 1) tag = "R7";
                        else if (md == 5) tag = "R8";
                        else if (md == 3) tag = "R9";
                        else if (sh != 0) tag = "R5";
                        else if (lg == 1) tag = "R3/R4";
                        else if (d == 255) tag = "R1";
                        else tag = "R2";

                        @(negedge clk);
                        cmd_hi     = {8'(d), 24'h00A5C3};
                        cmd_lo     = 32'(sh) << 18 | 32'(tr) << 15 | 32'(lv) << 14 |
                                     32'(lg) << 11 | 32'(md) << 8 | 32'(8'(d) ^ 8'h5A);
                        sender_idx = IDX_W'(snd);
                        cmd_lo_we  = 1'b1;
                        @(negedge clk);
                        cmd_lo_we  = 1'b0;
                        check({tag, " mask"}, 32'(out_mask), 32'(em));
                        check({tag, " arb_load"}, 32'(out_arb_load), 32'(ea));
                        check("R6 mode/vector echo", {21'd0, out_mode, out_vector},
                              {21'd0, 3'(md), 8'(d) ^ 8'h5A});
                        check("R10 valid pulse", 32'(out_valid), 1);
                        n++;
                        if (n % 16 == 0) begin
                            cmd_lo = ~cmd_lo;
                            cmd_hi = ~cmd_hi;
                            @(negedge clk);
                            check("R10 valid drop", 32'(out_valid), 0);
                            check("R10 hold mask", 32'(out_mask), 32'(em));
                            check("R10 hold arb", 32'(out_arb_load), 32'(ea));
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule